// File: doc/BRIEF.md
# Associative Address Translation Buffer

This block translates a 32-bit virtual address into a physical address through a small fully associative table. Every entry describes a pair of neighbouring pages (an even half and an odd half) that share one virtual tag. An entry carries a variable-size page mask, an 8-bit address space identifier, and a global flag that lets the entry match any identifier. Each half of the pair has its own frame number, its own valid flag and its own writable ("dirty") flag.

A lookup presents the virtual address, whether the access is a write, and the current 8-bit address space identifier. All entries are compared in parallel, and the lowest-numbered matching entry is used. The address bit just above the single-page offset selects the even or odd half. The result code, the physical address and the read and write permissions appear one clock after the inputs are sampled. An indexed write port replaces whole entries. The block does not choose which entry to replace.

Top module: `tlb_lookup_unit`

## Requirements
- R1: An entry hits when its virtual pair tag equals the address bits [31:13] in every position its page mask leaves clear, and either its global flag is set or its identifier equals `lk_asid`. If no entry has been written since reset, no entry hits.
- R2: Mask bit k of an entry (bits 0..18) removes address bit 13+k from the compare. Masks are contiguous runs of ones starting at bit 0. A mask of 0 gives 4 KB pages, and 3 gives 16 KB pages.
- R3: The half of the pair is chosen by the address bit just above the page offset. This is bit 12 for 4 KB pages and bit 14 for 16 KB pages. A value of 0 selects the even half (frame 0), and 1 selects the odd half (frame 1).
- R4: On success, `pa_o` is the selected frame number shifted left by 12, ORed with the address bits that lie below the selecting bit.
- R5: A hit whose selected valid flag is clear returns result 2'b10 (invalid), for reads and for writes alike.
- R6: A write that hits a valid half whose dirty flag is clear returns 2'b11 (dirty). A read of such a half succeeds.
- R7: On success the result is 2'b00, `rd_ok_o` is 1, and `wr_ok_o` equals the selected dirty flag.
- R8: When no entry hits, the result is 2'b01. For any result other than 2'b00, `pa_o`, `rd_ok_o` and `wr_ok_o` are 0.
- R9: When several entries hit, the lowest-indexed one decides the result, even if its selected half is invalid.
- R10: Outputs are registered. Inputs sampled at one rising edge produce the outputs seen after that edge. A lookup made in the same cycle as a write sees the old contents. Reset (synchronous, active low) forces the result to 2'b01 and the other outputs to 0.
- R11: When `wr_en` is high at a rising edge, entry `wr_idx` is fully replaced by the write fields. Later lookups see only the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_is_write | input | 1 | 1 for a store, 0 for a load |
| lk_asid | input | 8 | Current address space identifier |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry number to replace |
| wr_vpn2 | input | 19 | Virtual pair tag (address bits [31:13]) |
| wr_mask | input | 19 | Page mask; a set bit removes address bit 13+k from the compare |
| wr_global | input | 1 | Match regardless of identifier |
| wr_asid | input | 8 | Entry identifier |
| wr_pfn0 | input | 20 | Even-half frame number |
| wr_valid0 | input | 1 | Even-half valid |
| wr_dirty0 | input | 1 | Even-half writable |
| wr_pfn1 | input | 20 | Odd-half frame number |
| wr_valid1 | input | 1 | Odd-half valid |
| wr_dirty1 | input | 1 | Odd-half writable |
| pa_o | output | 32 | Translated physical address |
| rd_ok_o | output | 1 | Read permitted |
| wr_ok_o | output | 1 | Write permitted |
| result_o | output | 2 | 00 match, 01 no match, 10 invalid, 11 dirty |

## Verification
Lookups are tried against private and global entries, with both matching and foreign identifiers, which separates the identifier compare from the global override. Reads and writes go to even and odd halves of 4 KB and 16 KB pairs. These cases show that the half-select bit and the offset width follow the mask, and that a masked tag bit is ignored while the next bit up is not. Clean halves, invalid halves and doubly matching entries separate the dirty, invalid and priority outcomes. A write issued in the same cycle as a lookup confirms that the lookup sees the old contents and that the next lookup sees the new ones.

// File: rtl/tlb_pkg.sv
// Shared widths, entry layout and result codes for the translation buffer.
package tlb_pkg;
    localparam int VA_W       = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int ASID_W     = 8;
    localparam int VPN2_W     = VA_W - PAGE_SHIFT - 1;
    localparam int PFN_W      = VA_W - PAGE_SHIFT;
    localparam int PA_W       = PFN_W + PAGE_SHIFT;

    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        logic [VPN2_W-1:0] mask;
        logic              global_f;
        logic [ASID_W-1:0] asid;
        logic [PFN_W-1:0]  pfn0;
        logic              v0;
        logic              d0;
        logic [PFN_W-1:0]  pfn1;
        logic              v1;
        logic              d1;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        RES_MATCH   = 2'b00,
        RES_NOMATCH = 2'b01,
        RES_INVALID = 2'b10,
        RES_DIRTY   = 2'b11
    } tlb_res_e;
endpackage

// File: rtl/tlb_entry_array.sv
// Storage for all entries plus a per-entry "loaded" flag.
// Assumes the index is always in range; reset empties the table.
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [IDX_W-1:0]             wr_idx_i,
    input  tlb_entry_t                   wr_entry_i,
    output tlb_entry_t [NUM_ENTRIES-1:0] entry_o,
    output logic [NUM_ENTRIES-1:0]       present_o
);
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        // Replace one slot when the write port addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_o[g]   <= '0;
                present_o[g] <= 1'b0;
            end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                entry_o[g]   <= wr_entry_i;
                present_o[g] <= 1'b1;
            end
        end

        // R11: an addressed slot holds exactly the written fields next cycle
        p_slot_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && (wr_idx_i == IDX_W'(g))) |=>
                (entry_o[g] == $past(wr_entry_i)) && present_o[g]);
    end
endmodule

// File: rtl/tlb_tag_compare.sv
// One entry's hit logic: masked pair-tag compare and identifier check.
// Assumes the mask is a contiguous run of ones from bit 0.
module tlb_tag_compare
    import tlb_pkg::*;
(
    input  logic              present_i,
    input  logic [VPN2_W-1:0] ent_vpn2_i,
    input  logic [VPN2_W-1:0] ent_mask_i,
    input  logic              ent_global_i,
    input  logic [ASID_W-1:0] ent_asid_i,
    input  logic [VPN2_W-1:0] addr_vpn2_i,
    input  logic [ASID_W-1:0] cur_asid_i,
    output logic              hit_o
);
    logic tag_eq;
    logic id_ok;

    // Compare tags only where the mask does not hide the bit.
    always_comb begin
        tag_eq = (((addr_vpn2_i ^ ent_vpn2_i) & ~ent_mask_i) == '0);
        id_ok  = ent_global_i || (ent_asid_i == cur_asid_i);
        hit_o  = present_i && tag_eq && id_ok;
    end
endmodule

// File: rtl/tlb_first_hit.sv
// Picks the lowest-indexed hit and reports it as index and one-hot grant.
module tlb_first_hit #(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0] hit_i,
    output logic [NUM_ENTRIES-1:0] grant_o,
    output logic [IDX_W-1:0]       idx_o,
    output logic                   any_o
);
    // Scan from the top so the lowest hit is the last one written.
    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hit_i[i]) begin
                idx_o = IDX_W'(i);
                any_o = 1'b1;
            end
        end
        grant_o = any_o ? ({{(NUM_ENTRIES-1){1'b0}}, 1'b1} << idx_o) : '0;
    end
endmodule

// File: rtl/tlb_lookup_unit.sv
// Fully associative translation buffer with paired pages.
// Compares all entries at once, takes the lowest hit, picks the even or odd
// half by the bit above the page offset, checks valid/dirty, and registers
// the outcome. Assumes page masks are contiguous low-order runs of ones.
module tlb_lookup_unit
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              lk_is_write,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN2_W-1:0] wr_vpn2,
    input  logic [VPN2_W-1:0] wr_mask,
    input  logic              wr_global,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn0,
    input  logic              wr_valid0,
    input  logic              wr_dirty0,
    input  logic [PFN_W-1:0]  wr_pfn1,
    input  logic              wr_valid1,
    input  logic              wr_dirty1,
    output logic [PA_W-1:0]   pa_o,
    output logic              rd_ok_o,
    output logic              wr_ok_o,
    output logic [1:0]        result_o
);
    localparam int LOW_W = PAGE_SHIFT + 1;

    tlb_entry_t                   wr_entry;
    tlb_entry_t [NUM_ENTRIES-1:0] table_q;
    logic [NUM_ENTRIES-1:0]       present;
    logic [NUM_ENTRIES-1:0]       hit_vec;
    logic [NUM_ENTRIES-1:0]       grant;
    logic [IDX_W-1:0]             hit_idx;
    logic                         any_hit;

    logic [VA_W-1:0]  full_mask;
    logic [VA_W-1:0]  half_mask;
    logic             odd_half;
    logic [PFN_W-1:0] sel_pfn;
    logic             sel_valid;
    logic             sel_dirty;
    tlb_res_e         res_d;
    logic [PA_W-1:0]  pa_d;

    // Pack the write fields into one entry word.
    always_comb begin
        wr_entry.vpn2     = wr_vpn2;
        wr_entry.mask     = wr_mask;
        wr_entry.global_f = wr_global;
        wr_entry.asid     = wr_asid;
        wr_entry.pfn0     = wr_pfn0;
        wr_entry.v0       = wr_valid0;
        wr_entry.d0       = wr_dirty0;
        wr_entry.pfn1     = wr_pfn1;
        wr_entry.v1       = wr_valid1;
        wr_entry.d1       = wr_dirty1;
    end

    tlb_entry_array #(.NUM_ENTRIES(NUM_ENTRIES)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_idx_i   (wr_idx),
        .wr_entry_i (wr_entry),
        .entry_o    (table_q),
        .present_o  (present)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        tlb_tag_compare u_cmp (
            .present_i    (present[g]),
            .ent_vpn2_i   (table_q[g].vpn2),
            .ent_mask_i   (table_q[g].mask),
            .ent_global_i (table_q[g].global_f),
            .ent_asid_i   (table_q[g].asid),
            .addr_vpn2_i  (lk_vaddr[VA_W-1:LOW_W]),
            .cur_asid_i   (lk_asid),
            .hit_o        (hit_vec[g])
        );
    end

    tlb_first_hit #(.NUM_ENTRIES(NUM_ENTRIES)) u_first (
        .hit_i   (hit_vec),
        .grant_o (grant),
        .idx_o   (hit_idx),
        .any_o   (any_hit)
    );

    // Choose the half of the winning pair and its frame, valid and dirty.
    always_comb begin
        full_mask = {table_q[hit_idx].mask, {LOW_W{1'b1}}};
        half_mask = full_mask >> 1;
        odd_half  = |(lk_vaddr & full_mask & ~half_mask);
        sel_pfn   = odd_half ? table_q[hit_idx].pfn1 : table_q[hit_idx].pfn0;
        sel_valid = odd_half ? table_q[hit_idx].v1   : table_q[hit_idx].v0;
        sel_dirty = odd_half ? table_q[hit_idx].d1   : table_q[hit_idx].d0;
    end

    // Classify the access and form the physical address.
    always_comb begin
        if (!any_hit)                       res_d = RES_NOMATCH;
        else if (!sel_valid)                res_d = RES_INVALID;
        else if (lk_is_write && !sel_dirty) res_d = RES_DIRTY;
        else                                res_d = RES_MATCH;
        pa_d = (res_d == RES_MATCH)
             ? ({sel_pfn, {PAGE_SHIFT{1'b0}}} | (lk_vaddr & half_mask))
             : '0;
    end

    // Register the lookup outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= RES_NOMATCH;
            pa_o     <= '0;
            rd_ok_o  <= 1'b0;
            wr_ok_o  <= 1'b0;
        end else begin
            result_o <= res_d;
            pa_o     <= pa_d;
            rd_ok_o  <= (res_d == RES_MATCH);
            wr_ok_o  <= (res_d == RES_MATCH) && sel_dirty;
        end
    end

    // R9: at most one entry is granted, and only one that actually hits
    p_grant_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_grant_is_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~hit_vec) == '0) && (any_hit == (grant != '0)));
    // R6: a dirty result only ever follows a write request
    p_dirty_from_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (result_o == RES_DIRTY) |-> $past(lk_is_write));
    // R7: a success always grants read; write grant implies success
    p_read_on_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (result_o == RES_MATCH) |-> rd_ok_o);
    p_write_needs_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok_o |-> (rd_ok_o && (result_o == RES_MATCH)));
    // R8: failures carry no address and no permission
    p_fail_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (result_o != RES_MATCH) |-> ((pa_o == '0) && !rd_ok_o && !wr_ok_o));
endmodule

// File: tb/tlb_lookup_unit_bench.sv
module tlb_lookup_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_is_write = 1'b0;
    logic [7:0]  lk_asid = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [18:0] wr_vpn2 = '0;
    logic [18:0] wr_mask = '0;
    logic        wr_global = 1'b0;
    logic [7:0]  wr_asid = '0;
    logic [19:0] wr_pfn0 = '0;
    logic        wr_valid0 = 1'b0;
    logic        wr_dirty0 = 1'b0;
    logic [19:0] wr_pfn1 = '0;
    logic        wr_valid1 = 1'b0;
    logic        wr_dirty1 = 1'b0;
    logic [31:0] pa_o;
    logic        rd_ok_o;
    logic        wr_ok_o;
    logic [1:0]  result_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tlb_lookup_unit u_tlb_lookup_unit (
        .clk(clk), .rst_n(rst_n),
        .lk_vaddr(lk_vaddr), .lk_is_write(lk_is_write), .lk_asid(lk_asid),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2), .wr_mask(wr_mask),
        .wr_global(wr_global), .wr_asid(wr_asid),
        .wr_pfn0(wr_pfn0), .wr_valid0(wr_valid0), .wr_dirty0(wr_dirty0),
        .wr_pfn1(wr_pfn1), .wr_valid1(wr_valid1), .wr_dirty1(wr_dirty1),
        .pa_o(pa_o), .rd_ok_o(rd_ok_o), .wr_ok_o(wr_ok_o), .result_o(result_o)
    );

    task automatic expect_out(string req, logic [1:0] er, logic [31:0] epa,
                              logic erd, logic ewr);
        checks++;
        if (result_o !== er || pa_o !== epa || rd_ok_o !== erd || wr_ok_o !== ewr) begin
            fails++;
            $display("FAIL %s: got res=%b pa=%h rd=%b wr=%b, expected res=%b pa=%h rd=%b wr=%b",
                     req, result_o, pa_o, rd_ok_o, wr_ok_o, er, epa, erd, ewr);
        end
    endtask

    task automatic load_entry(logic [3:0] idx, logic [18:0] vpn2, logic [18:0] mask,
                              logic g, logic [7:0] asid,
                              logic [19:0] p0, logic v0, logic d0,
                              logic [19:0] p1, logic v1, logic d1);
        @(negedge clk);
        wr_idx = idx; wr_vpn2 = vpn2; wr_mask = mask; wr_global = g; wr_asid = asid;
        wr_pfn0 = p0; wr_valid0 = v0; wr_dirty0 = d0;
        wr_pfn1 = p1; wr_valid1 = v1; wr_dirty1 = d1;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic probe(logic [31:0] va, logic is_wr, logic [7:0] asid);
        @(negedge clk);
        lk_vaddr = va; lk_is_write = is_wr; lk_asid = asid;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        @(negedge clk);
        expect_out("R10 reset outputs", 2'b01, 32'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        probe(32'h0000_0000, 1'b0, 8'h00);
        expect_out("R1 empty table misses", 2'b01, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_small_pages;
        load_entry(4'd3, 19'h00200, 19'h0, 1'b0, 8'h05,
                   20'h12345, 1'b1, 1'b1, 20'h0ABCD, 1'b1, 1'b0);
        probe(32'h0040_0123, 1'b0, 8'h05);
        expect_out("R4 even read", 2'b00, 32'h1234_5123, 1'b1, 1'b1);
        probe(32'h0040_1456, 1'b0, 8'h05);
        expect_out("R3 odd read clean", 2'b00, 32'h0ABC_D456, 1'b1, 1'b0);
        probe(32'h0040_1456, 1'b1, 8'h05);
        expect_out("R6 write clean half", 2'b11, 32'h0, 1'b0, 1'b0);
        probe(32'h0040_0010, 1'b1, 8'h05);
        expect_out("R7 write dirty half", 2'b00, 32'h1234_5010, 1'b1, 1'b1);
        probe(32'h0040_0010, 1'b0, 8'h06);
        expect_out("R1 foreign identifier", 2'b01, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_global_invalid;
        load_entry(4'd5, 19'h08000, 19'h0, 1'b1, 8'h77,
                   20'h00100, 1'b0, 1'b1, 20'h00200, 1'b1, 1'b1);
        probe(32'h1000_0004, 1'b0, 8'h01);
        expect_out("R5 invalid read", 2'b10, 32'h0, 1'b0, 1'b0);
        probe(32'h1000_0004, 1'b1, 8'h01);
        expect_out("R5 invalid write", 2'b10, 32'h0, 1'b0, 1'b0);
        probe(32'h1000_1008, 1'b0, 8'h99);
        expect_out("R1 global override", 2'b00, 32'h0020_0008, 1'b1, 1'b1);
    endtask

    task automatic t_large_pages;
        load_entry(4'd7, 19'h10003, 19'h3, 1'b0, 8'h05,
                   20'h40000, 1'b1, 1'b1, 20'h50000, 1'b1, 1'b1);
        probe(32'h2000_3ABC, 1'b0, 8'h05);
        expect_out("R2 16K even, masked tag bits", 2'b00, 32'h4000_3ABC, 1'b1, 1'b1);
        probe(32'h2000_5ABC, 1'b0, 8'h05);
        expect_out("R3 16K odd via bit 14", 2'b00, 32'h5000_1ABC, 1'b1, 1'b1);
        probe(32'h2000_8000, 1'b0, 8'h05);
        expect_out("R2 bit above mask compared", 2'b01, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_priority;
        load_entry(4'd12, 19'h18000, 19'h0, 1'b1, 8'h00,
                   20'h000C0, 1'b1, 1'b1, 20'h0, 1'b0, 1'b0);
        load_entry(4'd9, 19'h18000, 19'h0, 1'b0, 8'h05,
                   20'h0009A, 1'b1, 1'b1, 20'h0, 1'b0, 1'b0);
        probe(32'h3000_0000, 1'b0, 8'h05);
        expect_out("R9 lowest hit wins", 2'b00, 32'h0009_A000, 1'b1, 1'b1);
        load_entry(4'd9, 19'h18000, 19'h0, 1'b0, 8'h05,
                   20'h0009A, 1'b0, 1'b1, 20'h0, 1'b0, 1'b0);
        probe(32'h3000_0000, 1'b0, 8'h05);
        expect_out("R9 lowest hit wins even if invalid", 2'b10, 32'h0, 1'b0, 1'b0);
        load_entry(4'd9, 19'h30000, 19'h0, 1'b0, 8'h05,
                   20'h0009A, 1'b1, 1'b1, 20'h0, 1'b0, 1'b0);
        probe(32'h3000_0000, 1'b0, 8'h05);
        expect_out("R11 rewritten slot no longer matches", 2'b00, 32'h000C_0000, 1'b1, 1'b1);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        lk_vaddr = 32'h3000_0000; lk_is_write = 1'b0; lk_asid = 8'h05;
        wr_idx = 4'd12; wr_vpn2 = 19'h38000; wr_mask = '0; wr_global = 1'b1; wr_asid = 8'h00;
        wr_pfn0 = 20'h000C0; wr_valid0 = 1'b1; wr_dirty0 = 1'b1;
        wr_pfn1 = '0; wr_valid1 = 1'b0; wr_dirty1 = 1'b0;
        wr_en = 1'b1;
        @(posedge clk);
        #1;
        expect_out("R10 lookup sees old contents", 2'b00, 32'h000C_0000, 1'b1, 1'b1);
        @(negedge clk);
        wr_en = 1'b0;
        probe(32'h3000_0000, 1'b0, 8'h05);
        expect_out("R11 old tag gone", 2'b01, 32'h0, 1'b0, 1'b0);
        probe(32'h7000_0FFC, 1'b1, 8'h42);
        expect_out("R11 new tag live", 2'b00, 32'h000C_0FFC, 1'b1, 1'b1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_small_pages();
        t_global_invalid();
        t_large_pages();
        t_priority();
        t_same_cycle();
        repeat (2) @(posedge clk);
        finish_run();
    end

    initial begin
        #200000;
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end
endmodule